// File: doc/BRIEF.md
# Control Cell Memory Transaction Processor

This block sits in a word-serial cell stream. It takes each cell in full, one 32-bit word per accepted cycle, and reads the module identifier the cell carries. A cell meant for another module is sent on unchanged, word for word. That cell may be for a module further down the chain, or it may be a response coming back from an earlier one.

A cell addressed to this block carries a batch of address/data pairs. Each pair is either a read or a write, as selected per pair, and all pairs go to one of two memory banks. The block runs the pairs in order on a simple request/acknowledge memory port. It then sends back one response cell that holds every address with the data that was written to it or read from it, and it closes that cell with a fresh checksum.

A matching cell is dropped without a response when its checksum fails or its pair count is too large. The sender's timeout then triggers a retransmission.

Cell layout, 20 words, word index first:
- w0: header, opaque and echoed.
- w1: identifier in bits [31:24], opcode in bits [23:16] (echoed), bank select in bit 8, and a per-pair write mask in bits [7:0], where bit p set means pair p is a write.
- w2: pair count in bits [7:0].
- w3..w18: the pairs, address word then data word. Pair p sits at words 3+2p and 4+2p.
- w19: XOR of w0..w18.

Top module: `ctlcell_proc`

## Requirements
- R1: After reset, out_valid and mem_req are low and in_ready is high.
- R2: A cell whose identifier (w1[31:24]) differs from MODULE_ID is sent out as exactly 20 words identical to the input, whatever its checksum, with no memory operation.
- R3: A matching cell with a valid checksum and a count of at most 8 produces exactly count memory operations, one per pair, in pair order 0 upward, on the bank given by w1[8]. It then produces exactly one 20-word response.
- R4: For a write pair (mask bit set), the memory receives the pair's address and data, and the response echoes both unchanged.
- R5: For a read pair (mask bit clear), the response holds the pair's address and the data the memory returned. A read after a write to the same address within one cell returns the written value.
- R6: The response echoes w0, w1 and w2 unchanged, and the address and data words of pairs at index count or above are zero.
- R7: The response's last word is the XOR of its words 0 to 18.
- R8: A matching cell whose last word is not the XOR of its words 0 to 18 produces no output and no memory operation.
- R9: A matching cell with a count above 8 produces no output and no memory operation. A count of 0 produces a response with no memory operation.
- R10: in_ready is low from the cell's last word until the response or forwarded cell has fully left. A raised mem_req holds its address, data, write and bank values until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input cell word |
| in_ready | output | 1 | Block accepts an input word |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output cell word |
| mem_req | output | 1 | Memory operation request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_bank | output | 1 | Bank select |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Operation complete; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The pair count is swept from 0 to 8, with write masks that vary by count and with alternating banks, so that every boundary between used and zeroed pair slots appears. Cells whose pairs all hit one address with alternating write and read show whether operations follow pair order. Cells read back after earlier writes show whether the bank and the write data reach memory. Foreign identifiers with good and bad checksums, a corrupted matching cell, and counts of 9 and 200 separate the pass-through path, the integrity drop and the count drop. A normal cell after each drop shows that the block recovers.

// File: rtl/ctlcell_pkg.sv
package ctlcell_pkg;
    localparam int WORD_W      = 32;
    localparam int MAX_PAIRS   = 8;
    localparam int HDR_WORDS   = 3;
    localparam int CELL_WORDS  = HDR_WORDS + 2 * MAX_PAIRS + 1;
    localparam int IDX_W       = $clog2(CELL_WORDS);
    localparam int PIDX_W      = $clog2(MAX_PAIRS + 1);
    localparam int PSEL_W      = $clog2(MAX_PAIRS);
    localparam int CNT_FIELD_W = 8;
    localparam int WORD_CTL    = 1;
    localparam int WORD_CNT    = 2;
    localparam int WORD_CKS    = CELL_WORDS - 1;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic [7:0]            id;
        logic [7:0]            opcode;
        logic [14-MAX_PAIRS:0] rsvd;
        logic                  bank;
        logic [MAX_PAIRS-1:0]  wmask;
    } ctl_word_t;

    typedef enum logic [1:0] {ST_RECV, ST_DECIDE, ST_MEM, ST_SEND} state_e;

    function automatic logic [IDX_W-1:0] addr_slot(input logic [PIDX_W-1:0] p);
        return IDX_W'(HDR_WORDS + 2 * int'(p));
    endfunction
endpackage

// File: rtl/ctlcell_rx.sv
module ctlcell_rx
    import ctlcell_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  word_t            word,
    output logic [IDX_W-1:0] idx,
    output logic             last,
    output logic             sum_ok
);
    word_t acc;

    assign last   = take && (idx == IDX_W'(WORD_CKS));
    assign sum_ok = (acc == word);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
            acc <= '0;
        end else if (take) begin
            if (last) begin
                idx <= '0;
                acc <= '0;
            end else begin
                idx <= idx + 1'b1;
                acc <= acc ^ word;
            end
        end
    end
endmodule

// File: rtl/ctlcell_memseq.sv
module ctlcell_memseq
    import ctlcell_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PIDX_W-1:0] count,
    input  logic              ack,
    output logic              req,
    output logic [PIDX_W-1:0] pidx,
    output logic              done
);
    logic              busy;
    logic [PIDX_W-1:0] cnt_q;

    assign req  = busy && (pidx < cnt_q);
    assign done = busy && (pidx >= cnt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            pidx  <= '0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            pidx  <= '0;
            cnt_q <= count;
        end else if (done) begin
            busy <= 1'b0;
        end else if (req && ack) begin
            pidx <= pidx + 1'b1;
        end
    end
endmodule

// File: rtl/ctlcell_proc.sv
module ctlcell_proc
    import ctlcell_pkg::*;
#(
    parameter logic [7:0] MODULE_ID = 8'h2A,
    parameter int         ADDR_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [31:0]       out_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_bank,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);
    word_t             cell_q [CELL_WORDS];
    state_e            st;
    logic              resp_q;
    logic              cks_ok_q;
    logic [IDX_W-1:0]  tx_idx;

    logic              take, rx_last, rx_ok;
    logic [IDX_W-1:0]  rx_idx;
    logic              seq_start, seq_done;
    logic [PIDX_W-1:0] pidx;
    logic [IDX_W-1:0]  slot_a, slot_d;
    ctl_word_t         ctl;
    logic [CNT_FIELD_W-1:0] cnt_field;
    logic              id_hit, count_ok;
    word_t             fold;

    assign in_ready  = (st == ST_RECV);
    assign take      = in_valid && in_ready;
    assign ctl       = ctl_word_t'(cell_q[WORD_CTL]);
    assign cnt_field = cell_q[WORD_CNT][CNT_FIELD_W-1:0];
    assign id_hit    = (ctl.id == MODULE_ID);
    assign count_ok  = (cnt_field <= CNT_FIELD_W'(MAX_PAIRS));
    assign seq_start = (st == ST_DECIDE) && id_hit && cks_ok_q && count_ok;

    ctlcell_rx u_rx (
        .clk(clk), .rst(rst), .take(take), .word(in_data),
        .idx(rx_idx), .last(rx_last), .sum_ok(rx_ok)
    );

    ctlcell_memseq u_seq (
        .clk(clk), .rst(rst), .start(seq_start),
        .count(cnt_field[PIDX_W-1:0]), .ack(mem_ack),
        .req(mem_req), .pidx(pidx), .done(seq_done)
    );

    assign slot_a    = addr_slot(pidx);
    assign slot_d    = slot_a + 1'b1;
    assign mem_addr  = cell_q[slot_a][ADDR_W-1:0];
    assign mem_wdata = cell_q[slot_d];
    assign mem_we    = ctl.wmask[pidx[PSEL_W-1:0]];
    assign mem_bank  = ctl.bank;

    always_comb begin
        fold = '0;
        for (int i = 0; i < WORD_CKS; i++) fold = fold ^ cell_q[i];
    end

    assign out_valid = (st == ST_SEND);
    assign out_data  = (resp_q && tx_idx == IDX_W'(WORD_CKS)) ? fold : cell_q[tx_idx];

    always_ff @(posedge clk) begin
        if (take) cell_q[rx_idx] <= in_data;
        if (seq_start) begin
            for (int p = 0; p < MAX_PAIRS; p++) begin
                if (p >= int'(cnt_field)) begin
                    cell_q[HDR_WORDS + 2 * p]     <= '0;
                    cell_q[HDR_WORDS + 2 * p + 1] <= '0;
                end
            end
        end
        if (mem_req && mem_ack && !mem_we) cell_q[slot_d] <= mem_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_RECV;
            resp_q   <= 1'b0;
            cks_ok_q <= 1'b0;
            tx_idx   <= '0;
        end else begin
            unique case (st)
                ST_RECV: if (rx_last) begin
                    st       <= ST_DECIDE;
                    cks_ok_q <= rx_ok;
                end
                ST_DECIDE: begin
                    tx_idx <= '0;
                    if (!id_hit) begin
                        resp_q <= 1'b0;
                        st     <= ST_SEND;
                    end else if (seq_start) begin
                        resp_q <= 1'b1;
                        st     <= ST_MEM;
                    end else begin
                        st <= ST_RECV;
                    end
                end
                ST_MEM: if (seq_done) st <= ST_SEND;
                ST_SEND: begin
                    tx_idx <= tx_idx + 1'b1;
                    if (tx_idx == IDX_W'(WORD_CKS)) st <= ST_RECV;
                end
                default: st <= ST_RECV;
            endcase
        end
    end
endmodule

// File: rtl/ctlcell_chk.sv
module ctlcell_chk
    import ctlcell_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              out_valid,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic              mem_bank,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata
);
    logic [IDX_W-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) run <= '0;
        else if (out_valid) run <= (run == IDX_W'(WORD_CKS)) ? '0 : run + 1'b1;
        else run <= '0;
    end

    assert_stall_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_bank) && $stable(mem_wdata)));

    assert_mem_after_cell_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (!in_ready && !out_valid));

    assert_cell_len_R3: assert property (@(posedge clk) disable iff (rst)
        (run != '0) |-> out_valid);
endmodule

bind ctlcell_proc ctlcell_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we), .mem_bank(mem_bank),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/tb_ctlcell_proc.sv
`timescale 1ns/100ps
module tb_ctlcell_proc;
    localparam logic [7:0] MY_ID = 8'h2A;
    localparam int ADDR_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic in_ready, out_valid, mem_req, mem_we, mem_bank;
    logic [31:0] out_data, mem_wdata;
    logic [ADDR_W-1:0] mem_addr;
    logic mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int fails = 0;
    int ncap = 0;
    int ops_n = 0;
    int viol = 0;
    int seq = 0;
    logic [31:0] cap [1024];
    logic [31:0] mdl [2][16];
    logic [31:0] refm [2][16];
    logic [31:0] cw [20];
    logic [31:0] ew [20];

    always #2.5 clk = ~clk;

    ctlcell_proc #(.MODULE_ID(MY_ID), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .mem_req(mem_req), .mem_we(mem_we),
        .mem_bank(mem_bank), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] init_val(input int b, input int a);
        return 32'h5A5A_0000 ^ (32'(b) << 8) ^ 32'(a);
    endfunction

    // memory model and output monitor, acting away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            for (int b = 0; b < 2; b++)
                for (int a = 0; a < 16; a++) mdl[b][a] = init_val(b, a);
            mem_ack = 1'b0;
        end else begin
            if (mem_req && !mem_ack) begin
                mem_ack = 1'b1;
                ops_n++;
                if (mem_we) mdl[mem_bank][mem_addr[3:0]] = mem_wdata;
                mem_rdata = mdl[mem_bank][mem_addr[3:0]];
            end else begin
                mem_ack = 1'b0;
            end
            if (out_valid) begin
                if (ncap < 1024) cap[ncap] = out_data;
                ncap++;
            end
            if (out_valid && in_ready) viol++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_cell(input logic [7:0] id, input logic bank, input logic [7:0] mask,
                            input logic [7:0] cnt, input bit corrupt, input bit same_addr,
                            input string tag);
        logic [31:0] f;
        int nexp, expops, c0, o0;
        bit fwd, good;
        seq++;
        cw[0] = 32'hC311_0000 + 32'(seq);
        cw[1] = {id, 8'h47, 7'h0, bank, mask};
        cw[2] = {24'h0, cnt};
        for (int p = 0; p < 8; p++) begin
            cw[3 + 2*p] = same_addr ? 32'h0001_0004 : (32'h0001_0000 | 32'((seq + p*3) & 7));
            cw[4 + 2*p] = 32'hD000_0000 | (32'(seq) << 8) | 32'(p);
        end
        f = '0;
        for (int i = 0; i < 19; i++) f = f ^ cw[i];
        cw[19] = f ^ (corrupt ? 32'h1 : 32'h0);

        fwd  = (id != MY_ID);
        good = !fwd && !corrupt && (cnt <= 8);
        for (int i = 0; i < 20; i++) ew[i] = cw[i];
        nexp = 0; expops = 0;
        if (fwd) nexp = 20;
        else if (good) begin
            nexp = 20; expops = int'(cnt);
            for (int p = 0; p < 8; p++) begin
                if (p < int'(cnt)) begin
                    if (mask[p]) refm[bank][cw[3+2*p][3:0]] = cw[4+2*p];
                    else ew[4+2*p] = refm[bank][cw[3+2*p][3:0]];
                end else begin
                    ew[3+2*p] = '0;
                    ew[4+2*p] = '0;
                end
            end
            f = '0;
            for (int i = 0; i < 19; i++) f = f ^ ew[i];
            ew[19] = f;
        end

        c0 = ncap; o0 = ops_n;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = cw[i];
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (80) @(negedge clk);

        chk((ncap - c0) == nexp, {tag, " word count"}, 32'(ncap - c0), 32'(nexp));
        chk((ops_n - o0) == expops, {tag, " memory ops"}, 32'(ops_n - o0), 32'(expops));
        if ((ncap - c0) == nexp) begin
            for (int i = 0; i < nexp; i++) begin
                string wt;
                if (fwd) wt = "R2 forwarded word";
                else if (i < 3) wt = "R6 echoed header";
                else if (i == 19) wt = "R7 checksum";
                else if ((i - 3) / 2 >= int'(cnt)) wt = "R6 unused slot";
                else if (mask[(i - 3) / 2]) wt = "R4 write pair";
                else wt = "R5 read pair";
                chk(cap[c0 + i] === ew[i], $sformatf("%s (%s, word %0d)", wt, tag, i), cap[c0 + i], ew[i]);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int a = 0; a < 16; a++) refm[b][a] = init_val(b, a);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 0);
        chk(mem_req == 1'b0, "R1 mem_req after reset", 32'(mem_req), 0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 1);

        run_cell(8'h11, 1'b0, 8'hFF, 8'd4, 1'b0, 1'b0, "R2 foreign id");
        run_cell(8'h2B, 1'b1, 8'h0F, 8'd8, 1'b1, 1'b0, "R2 foreign id bad checksum");

        for (int c = 0; c <= 8; c++) begin
            logic [7:0] m;
            m = (8'hA5 << (c % 8)) | (8'hA5 >> (8 - (c % 8)));
            run_cell(MY_ID, c[0], m, 8'(c), 1'b0, 1'b0, $sformatf("R3 sweep count %0d", c));
        end

        run_cell(MY_ID, 1'b0, 8'h55, 8'd8, 1'b0, 1'b1, "R5 write-then-read same address");
        run_cell(MY_ID, 1'b1, 8'hFF, 8'd8, 1'b0, 1'b0, "R4 all writes bank1");
        run_cell(MY_ID, 1'b1, 8'h00, 8'd8, 1'b0, 1'b0, "R5 readback bank1");
        run_cell(MY_ID, 1'b0, 8'h00, 8'd8, 1'b0, 1'b0, "R5 readback bank0");

        run_cell(MY_ID, 1'b0, 8'hFF, 8'd3, 1'b1, 1'b0, "R8 corrupted checksum");
        run_cell(MY_ID, 1'b0, 8'h00, 8'd2, 1'b0, 1'b0, "R8 recovery");
        run_cell(MY_ID, 1'b0, 8'hFF, 8'd9, 1'b0, 1'b0, "R9 count nine");
        run_cell(MY_ID, 1'b1, 8'hFF, 8'd200, 1'b0, 1'b0, "R9 count 200");
        run_cell(MY_ID, 1'b0, 8'h00, 8'd0, 1'b0, 1'b0, "R9 count zero");
        run_cell(MY_ID, 1'b1, 8'h00, 8'd8, 1'b0, 1'b0, "R9 bank1 untouched by rejects");

        chk(viol == 0, "R10 in_ready high while output active", 32'(viol), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule